// File: doc/BRIEF.md
# Bypassable Split-Field Pixel Clock Divider

This block produces the pixel-rate enable for a display timing pipeline from a faster reference clock. The division ratio comes from a 32-bit timing configuration word. In that word the divisor code is split into two separate fields, and a bypass flag sits beside them. When the bypass flag is set, the enable is high on every reference cycle. When it is clear, the enable pulses once every `code + 2` cycles. Here `code` is the high field placed above the low field.

The configuration word can be loaded in full through a word-write port and read back at all times. A second write port updates only the two divisor fields and the bypass flag. Software can therefore retune the pixel rate without a read-modify-write of the polarity and line-length bits that share the word.

A new setting is adopted only when the running count wraps, so no enable period is ever shortened or stretched mid-count. The divisor that is currently in effect is reported as a plain number. Software converts that number to a rate by dividing the reference rate and rounding up.

Top module: `pclk_divider`

## Requirements
- R1: After reset the configuration word reads 0x0000_0000, the reported divisor is 2 and `pix_en` is low during reset.
- R2: A word write (`wr_en` high, `fld_wr` low) stores all 32 bits of `wr_data`, which read back on `rd_data` from the next cycle.
- R3: A field write (`fld_wr` high) changes only bits [4:0] (from `fld_code[4:0]`), bits [31:27] (from `fld_code[9:5]`) and bit 26 (from `fld_bypass`). Bits [25:5] keep their values.
- R4: When both writes occur in the same cycle, the word write is applied first and the field write then overrides the divisor fields and bypass bit.
- R5: With bit 26 of the active setting set, `div_eff` reads 1 and `pix_en` is high on every cycle.
- R6: With bit 26 clear, the divisor is {bits[31:27], bits[4:0]} + 2 and `pix_en` is a single-cycle pulse repeating every divisor cycles. The smallest such divisor is 2.
- R7: The largest divisor is 1025 (code 1023), giving one pulse per 1025 cycles.
- R8: A changed setting is adopted only in the cycle after a `pix_en` pulse. Until then `div_eff` and the pulse spacing keep the old value.
- R9: `div_eff` always reports the active divisor, in the range 1 to 1025, encoded as an unsigned 11-bit number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Load the whole configuration word |
| wr_data | input | 32 | Word to load |
| fld_wr | input | 1 | Update divisor fields and bypass bit only |
| fld_bypass | input | 1 | New bypass flag for a field write |
| fld_code | input | 10 | New divisor code (divisor minus two) for a field write |
| rd_data | output | 32 | Current configuration word |
| pix_en | output | 1 | Pixel clock enable |
| div_eff | output | 11 | Divisor currently in effect |

## Verification
The assertions check on every cycle that the reported divisor stays within its legal range and changes only right after a pulse. They also check that bypass keeps the enable high, that pulses never sit back to back while counting, and that each write type leaves the right bits of the word. The absolute pulse spacing at the bypass setting, at divide-by-2 and at the largest divisor is only shown by the bench's period measurements. So are the merge order of simultaneous writes and a mid-count retune that must wait for the wrap. Those measurements are backed by a cycle-accurate reference model.

// File: rtl/pclk_div_pkg.sv
package pclk_div_pkg;
  // Default layout of the timing configuration word
  localparam int unsigned DEF_CFG_W   = 32;
  localparam int unsigned DEF_LO_W    = 5;
  localparam int unsigned DEF_LO_LSB  = 0;
  localparam int unsigned DEF_HI_W    = 5;
  localparam int unsigned DEF_HI_LSB  = 27;
  localparam int unsigned DEF_BYP_BIT = 26;
  localparam int unsigned DEF_SYNC    = 2;
  // Fixed offset between stored code and divisor
  localparam int unsigned CODE_OFFSET = 2;
endpackage

// File: rtl/pclk_rst_sync.sv
module pclk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b0;
          else        stage_q[i] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b0;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_sync_n = stage_q[STAGES-1];
endmodule

// File: rtl/pclk_cfg_reg.sv
module pclk_cfg_reg #(
  parameter int unsigned CFG_W   = 32,
  parameter int unsigned LO_W    = 5,
  parameter int unsigned LO_LSB  = 0,
  parameter int unsigned HI_W    = 5,
  parameter int unsigned HI_LSB  = 27,
  parameter int unsigned BYP_BIT = 26,
  localparam int unsigned CODE_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic              fld_wr,
  input  logic              fld_bypass,
  input  logic [CODE_W-1:0] fld_code,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              prog_byp,
  output logic [CODE_W-1:0] prog_code
);
  logic [CFG_W-1:0] cfg_d;
  logic             cfg_load;

  // Next-state: word write first, field write merged on top
  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d = wr_data;
    end
    if (fld_wr) begin
      cfg_d[LO_LSB +: LO_W] = fld_code[LO_W-1:0];
      cfg_d[HI_LSB +: HI_W] = fld_code[CODE_W-1:LO_W];
      cfg_d[BYP_BIT]        = fld_bypass;
    end
  end

  assign cfg_load = wr_en | fld_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_load) begin
      cfg_q <= cfg_d;
    end
  end

  // High field joins above the low field
  assign prog_code = {cfg_q[HI_LSB +: HI_W], cfg_q[LO_LSB +: LO_W]};
  assign prog_byp  = cfg_q[BYP_BIT];
endmodule

// File: rtl/pclk_div_core.sv
module pclk_div_core
  import pclk_div_pkg::*;
#(
  parameter int unsigned CODE_W = 10,
  localparam int unsigned CNT_W = CODE_W + 1,
  localparam int unsigned EFF_W = CODE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_byp,
  input  logic [CODE_W-1:0] prog_code,
  output logic              pix_en,
  output logic [EFF_W-1:0]  div_eff
);
  logic              act_byp_q;
  logic [CODE_W-1:0] act_code_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_d;
  logic [CNT_W-1:0]  cnt_last;
  logic              wrap;

  // Terminal count is divisor - 1 = code + 1
  assign cnt_last = {1'b0, act_code_q} + CNT_W'(CODE_OFFSET - 1);
  assign wrap     = act_byp_q | (cnt_q == cnt_last);

  always_comb begin
    if (wrap) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Setting adopted only at a wrap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_byp_q  <= 1'b0;
      act_code_q <= '0;
    end else if (wrap) begin
      act_byp_q  <= prog_byp;
      act_code_q <= prog_code;
    end
  end

  assign pix_en  = wrap;
  assign div_eff = act_byp_q ? EFF_W'(1)
                             : ({1'b0, act_code_q} + EFF_W'(CODE_OFFSET));
endmodule

// File: rtl/pclk_divider.sv
module pclk_divider
  import pclk_div_pkg::*;
#(
  parameter int unsigned CFG_W   = DEF_CFG_W,
  parameter int unsigned LO_W    = DEF_LO_W,
  parameter int unsigned LO_LSB  = DEF_LO_LSB,
  parameter int unsigned HI_W    = DEF_HI_W,
  parameter int unsigned HI_LSB  = DEF_HI_LSB,
  parameter int unsigned BYP_BIT = DEF_BYP_BIT,
  parameter int unsigned SYNC    = DEF_SYNC,
  localparam int unsigned CODE_W = LO_W + HI_W,
  localparam int unsigned EFF_W  = CODE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic              fld_wr,
  input  logic              fld_bypass,
  input  logic [CODE_W-1:0] fld_code,
  output logic [CFG_W-1:0]  rd_data,
  output logic              pix_en,
  output logic [EFF_W-1:0]  div_eff
);
  logic              rst_sync_n;
  logic              prog_byp;
  logic [CODE_W-1:0] prog_code;

  pclk_rst_sync #(.STAGES(SYNC)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pclk_cfg_reg #(
    .CFG_W(CFG_W), .LO_W(LO_W), .LO_LSB(LO_LSB),
    .HI_W(HI_W), .HI_LSB(HI_LSB), .BYP_BIT(BYP_BIT)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .fld_wr     (fld_wr),
    .fld_bypass (fld_bypass),
    .fld_code   (fld_code),
    .cfg_q      (rd_data),
    .prog_byp   (prog_byp),
    .prog_code  (prog_code)
  );

  pclk_div_core #(.CODE_W(CODE_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .prog_byp  (prog_byp),
    .prog_code (prog_code),
    .pix_en    (pix_en),
    .div_eff   (div_eff)
  );
endmodule

// File: rtl/pclk_divider_chk.sv
module pclk_divider_chk #(
  parameter int unsigned CFG_W   = 32,
  parameter int unsigned LO_W    = 5,
  parameter int unsigned LO_LSB  = 0,
  parameter int unsigned HI_W    = 5,
  parameter int unsigned HI_LSB  = 27,
  parameter int unsigned BYP_BIT = 26,
  localparam int unsigned CODE_W = LO_W + HI_W,
  localparam int unsigned EFF_W  = CODE_W + 1
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              wr_en,
  input logic [CFG_W-1:0]  wr_data,
  input logic              fld_wr,
  input logic [CFG_W-1:0]  rd_data,
  input logic              pix_en,
  input logic [EFF_W-1:0]  div_eff
);
  localparam logic [EFF_W-1:0] MAX_EFF = EFF_W'((1 << CODE_W) + 1);

  logic [EFF_W-1:0] word_eff;
  logic [CFG_W-1:0] keep_mask;

  always_comb begin
    keep_mask = '1;
    keep_mask[LO_LSB +: LO_W] = '0;
    keep_mask[HI_LSB +: HI_W] = '0;
    keep_mask[BYP_BIT]        = 1'b0;
  end

  assign word_eff = rd_data[BYP_BIT] ? EFF_W'(1)
                  : EFF_W'({rd_data[HI_LSB +: HI_W], rd_data[LO_LSB +: LO_W]}) + EFF_W'(2);

  AST_EFF_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (div_eff >= EFF_W'(1)) && (div_eff <= MAX_EFF)); // R9
  AST_EFF_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pix_en |=> $stable(div_eff)); // R8
  AST_WRAP_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pix_en |=> div_eff == $past(word_eff)); // R8
  AST_BYPASS_EN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (div_eff == EFF_W'(1)) |-> pix_en); // R5
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pix_en && !rd_data[BYP_BIT]) |=> !pix_en); // R6
  AST_WORD_STORE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !fld_wr) |=> rd_data == $past(wr_data)); // R2
  AST_FIELD_KEEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fld_wr && !wr_en) |=> (rd_data & keep_mask) == $past(rd_data & keep_mask)); // R3
  AST_MERGE_KEEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fld_wr && wr_en) |=> (rd_data & keep_mask) == $past(wr_data & keep_mask)); // R4
endmodule

bind pclk_divider pclk_divider_chk #(
  .CFG_W(CFG_W), .LO_W(LO_W), .LO_LSB(LO_LSB),
  .HI_W(HI_W), .HI_LSB(HI_LSB), .BYP_BIT(BYP_BIT)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .fld_wr     (fld_wr),
  .rd_data    (rd_data),
  .pix_en     (pix_en),
  .div_eff    (div_eff)
);

// File: tb/pclk_divider_bench.sv
`timescale 1ns/1ps
module pclk_divider_bench;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        fld_wr;
  logic        fld_bypass;
  logic [9:0]  fld_code;
  logic [31:0] rd_data;
  logic        pix_en;
  logic [10:0] div_eff;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  pclk_divider u_pclk_divider (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .fld_wr(fld_wr), .fld_bypass(fld_bypass), .fld_code(fld_code),
    .rd_data(rd_data), .pix_en(pix_en), .div_eff(div_eff)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Behavioural reference model
  logic [31:0] m_cfg;
  bit          m_byp;
  int          m_code;
  int          m_cnt;
  int          m_sync;

  function automatic bit m_pix();
    return m_byp || (m_cnt == m_code + 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg <= 32'h0; m_byp <= 0; m_code <= 0; m_cnt <= 0; m_sync <= 0;
    end else if (m_sync < 2) begin
      m_sync <= m_sync + 1;
    end else begin
      logic [31:0] nc;
      nc = m_cfg;
      if (wr_en) nc = wr_data;
      if (fld_wr) begin
        nc[4:0]   = fld_code[4:0];
        nc[31:27] = fld_code[9:5];
        nc[26]    = fld_bypass;
      end
      m_cfg <= nc;
      if (m_pix()) begin
        m_cnt  <= 0;
        m_byp  <= m_cfg[26];
        m_code <= int'({m_cfg[31:27], m_cfg[4:0]});
      end else begin
        m_cnt <= m_cnt + 1;
      end
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 rd_data", rd_data, m_cfg);
      check("R6 pix_en", pix_en, m_pix());
      check("R9 div_eff", div_eff, m_byp ? 1 : m_code + 2);
    end
  end

  task automatic word_write(input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic field_write(input bit byp, input logic [9:0] code);
    @(negedge clk); fld_wr = 1; fld_bypass = byp; fld_code = code;
    @(negedge clk); fld_wr = 0;
  endtask

  task automatic measure(input string req, input int exp);
    int n;
    @(negedge clk);
    while (!pix_en) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (!pix_en);
    check(req, n, exp);
  endtask

  initial begin
    rst_n = 0; wr_en = 0; wr_data = '0; fld_wr = 0; fld_bypass = 0; fld_code = '0;
    repeat (3) @(negedge clk);
    check("R1 pix_en low in reset", pix_en, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 reset word", rd_data, 32'h0);
    check("R1 reset divisor", div_eff, 2);
    measure("R1 reset period", 2);

    // R2 full word, divisor 359
    word_write(32'h5A5A_A5A5);
    check("R2 word readback", rd_data, 32'h5A5A_A5A5);
    measure("R6 period code 357", 359);
    measure("R6 period code 357 again", 359);

    // R3 field write: bypass, other bits kept
    field_write(1'b1, 10'd0);
    check("R3 fields only", rd_data, 32'h065A_A5A0);
    measure("R5 bypass period", 1);
    check("R5 bypass divisor", div_eff, 1);

    // R6 smallest divide
    field_write(1'b0, 10'd0);
    check("R3 bits kept", rd_data, 32'h025A_A5A0);
    measure("R6 divide by 2", 2);
    measure("R6 divide by 2 again", 2);

    // R7 maximum divide
    field_write(1'b0, 10'd1023);
    measure("R7 max period", 1025);
    check("R7 max divisor", div_eff, 1025);

    // R8 retune mid-count waits for wrap
    @(negedge clk); while (!pix_en) @(negedge clk);
    repeat (5) @(negedge clk);
    field_write(1'b0, 10'd3);
    repeat (20) @(negedge clk);
    check("R8 old divisor held", div_eff, 1025);
    measure("R8 new period after wrap", 5);

    // R4 simultaneous writes
    @(negedge clk);
    wr_en = 1; wr_data = 32'hFFFF_FFFF;
    fld_wr = 1; fld_bypass = 0; fld_code = 10'h2A3;
    @(negedge clk); wr_en = 0; fld_wr = 0;
    check("R4 merge order", rd_data, 32'hABFF_FFE3);
    measure("R4 merged period", 677);

    // R2 word write turning bypass on directly
    word_write(32'h0400_0000);
    measure("R5 bypass via word", 1);

    repeat (4) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    n_tests++; n_fail++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule